// File: doc/BRIEF.md
# Double-Buffered Corner-Turn Frame Buffer

This block sits between a row transform and a column transform in a two-dimensional FFT pipeline, or at the end of such a pipeline to put results back in order. It accepts a stream of N×N frames in row-major order and emits the same frames column by column. Two memory banks alternate roles each frame. One bank fills with the arriving frame while the other drains the previous frame, so a new frame can be accepted every N² samples with no stall.

The transpose costs no extra cycles. The write address counts row-major. The read address is the same count with its two index fields swapped. One counter drives the write address, the read address, the bank roles and the output multiplexer. This keeps all of them in lock-step. The counter's column and row indices leave the block with each output sample, so a downstream coefficient table can look up the matching entry.

The stream uses a valid signal only. There is no ready signal and no back-pressure. The block accepts every sample that arrives with `in_valid`. Readout is paced by the input, so a frame drains only while the next frame is being written. A final frame therefore needs one more frame of input, dummy data if needed, to flush it out. The real and imaginary parts are held in separate memory planes. With `COMPLEX` set to 0, only the real plane is built and `out_im` reads zero.

Top module: `corner_turn_buf`

## Requirements
- R1: While `rst_n` is low, and after reset until output starts, `out_valid` and `out_sof` are 0.
- R2: No output appears while the first frame of N² samples is being written. `out_valid` stays 0 until the first input sample of the second frame has been accepted.
- R3: Input sample number i of frame F (i = r·N + c, with r the row and c the column) comes out of the block as output sample number c·N + r of output frame F.
- R4: Once N² samples have been accepted, `out_valid` goes high exactly one cycle after each accepted input sample. It is low in a cycle that does not follow an accepted sample.
- R5: `out_sof` is high on the first output sample of each frame, the sample where row and column are both 0, and low on every other cycle.
- R6: With each valid output sample k of a frame, `out_col` = k / N and `out_row` = k mod N.
- R7: Idle cycles in `in_valid` in the middle of a frame pause both writing and readout. No sample is lost and the order does not change.
- R8: Frames sent back to back with no idle cycle stream through without stalling. Each frame after the first delivers exactly N² output samples and one `out_sof`.
- R9: With `COMPLEX` = 1, the imaginary input is reordered in exactly the same way as the real input, sample for sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | DATA_W | Real part of input sample, row-major order |
| in_im | input | DATA_W | Imaginary part of input sample |
| out_valid | output | 1 | Output sample present this cycle |
| out_sof | output | 1 | First sample of an output frame |
| out_re | output | DATA_W | Real part of output sample, column-major order |
| out_im | output | DATA_W | Imaginary part of output sample (0 when COMPLEX = 0) |
| out_row | output | LOG_N | Row index of the output sample |
| out_col | output | LOG_N | Column index of the output sample |

## Verification
The hardest conditions to reach are the bank hand-over and the pause in readout. At the hand-over, the sample that completes one frame and the sample that starts the next must land in different banks with nothing lost. In a pause, an idle input cycle must also freeze the drain of the other bank. The stimulus sends several frames back to back, so the swap happens on consecutive cycles. It then sends a frame with idle gaps of varying length placed at irregular sample positions. Each input value is a function of its frame number and position, so any sample that is dropped, duplicated or written to the wrong bank shows up as a data mismatch at a known output index.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic {
    BANK0 = 1'b0,
    BANK1 = 1'b1
  } bank_t;

  function automatic bank_t bank_other(bank_t b);
    return (b == BANK0) ? BANK1 : BANK0;
  endfunction

endpackage

// File: rtl/ctb_seq_ctrl.sv
module ctb_seq_ctrl
  import ctb_pkg::*;
#(
  parameter int LOG_N = 4,
  localparam int AW = 2 * LOG_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output bank_t            wr_bank,
  output logic [AW-1:0]    wr_addr,
  output logic [AW-1:0]    rd_addr,
  output logic [LOG_N-1:0] pos_hi,
  output logic [LOG_N-1:0] pos_lo,
  output logic             primed,
  output logic             at_origin
);

  logic [AW-1:0] cnt_q;
  logic          wrap;

  assign wrap = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wr_bank <= BANK0;
      primed  <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) begin
        wr_bank <= bank_other(wr_bank);
        primed  <= 1'b1;
      end
    end
  end

  // Upper field is the row on the write side, the column on the read side.
  assign pos_hi    = cnt_q[AW-1:LOG_N];
  assign pos_lo    = cnt_q[LOG_N-1:0];
  assign wr_addr   = cnt_q;
  assign rd_addr   = {pos_lo, pos_hi};
  assign at_origin = (cnt_q == '0);

endmodule

// File: rtl/ctb_bank_ram.sv
module ctb_bank_ram #(
  parameter int W  = 16,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ctb_plane.sv
module ctb_plane
  import ctb_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          adv,
  input  bank_t         wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  wr_data,
  input  bank_t         rd_sel,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic mine;
    assign mine = (wr_bank == bank_t'(1'(b)));
    ctb_bank_ram #(.W(W), .AW(AW)) i_ram (
      .clk   (clk),
      .we    (adv && mine),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (adv && !mine),
      .raddr (rd_addr),
      .rdata (bank_q[b])
    );
  end

  assign rd_data = bank_q[rd_sel];

endmodule

// File: rtl/corner_turn_buf.sv
module corner_turn_buf
  import ctb_pkg::*;
#(
  parameter int LOG_N   = 4,
  parameter int DATA_W  = 16,
  parameter bit COMPLEX = 1'b1,
  localparam int AW = 2 * LOG_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              out_valid,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im,
  output logic [LOG_N-1:0]  out_row,
  output logic [LOG_N-1:0]  out_col
);

  bank_t             wr_bank;
  bank_t             rd_sel_q;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [LOG_N-1:0]  pos_hi, pos_lo;
  logic              primed, at_origin;

  ctb_seq_ctrl #(.LOG_N(LOG_N)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (in_valid),
    .wr_bank   (wr_bank),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .pos_hi    (pos_hi),
    .pos_lo    (pos_lo),
    .primed    (primed),
    .at_origin (at_origin)
  );

  // Output side registers align with the one-cycle memory read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      rd_sel_q  <= BANK1;
    end else begin
      out_valid <= in_valid && primed;
      out_sof   <= in_valid && primed && at_origin;
      if (in_valid) begin
        out_col  <= pos_hi;
        out_row  <= pos_lo;
        rd_sel_q <= bank_other(wr_bank);
      end
    end
  end

  ctb_plane #(.W(DATA_W), .AW(AW)) i_plane_re (
    .clk     (clk),
    .adv     (in_valid),
    .wr_bank (wr_bank),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .wr_data (in_re),
    .rd_sel  (rd_sel_q),
    .rd_data (out_re)
  );

  if (COMPLEX) begin : g_imag
    ctb_plane #(.W(DATA_W), .AW(AW)) i_plane_im (
      .clk     (clk),
      .adv     (in_valid),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .wr_data (in_im),
      .rd_sel  (rd_sel_q),
      .rd_data (out_im)
    );
  end else begin : g_real_only
    assign out_im = '0;
  end

endmodule

// File: rtl/corner_turn_buf_chk.sv
module corner_turn_buf_chk #(
  parameter int LOG_N = 4,
  localparam int NN = 1 << (2 * LOG_N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_sof,
  input logic [LOG_N-1:0] out_row,
  input logic [LOG_N-1:0] out_col
);

  logic [2*LOG_N:0] seen_q;
  logic             full;

  assign full = (seen_q == (2*LOG_N+1)'(NN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (in_valid && !full) seen_q <= seen_q + 1'b1;
  end

  // R2
  no_early_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |=> !out_valid);

  // R4
  idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4
  primed_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> out_valid);

  // R5
  sof_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R5
  sof_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == (out_row == '0 && out_col == '0)));

endmodule

bind corner_turn_buf corner_turn_buf_chk #(.LOG_N(LOG_N)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_row   (out_row),
  .out_col   (out_col)
);

// File: tb/test_corner_turn_buf.sv
module test_corner_turn_buf;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_N  = 4;
  localparam int N      = 1 << LOG_N;
  localparam int NN     = N * N;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_re = '0;
  logic [DATA_W-1:0] in_im = '0;
  logic              out_valid, out_sof;
  logic [DATA_W-1:0] out_re, out_im;
  logic [LOG_N-1:0]  out_row, out_col;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  corner_turn_buf #(.LOG_N(LOG_N), .DATA_W(DATA_W), .COMPLEX(1'b1)) i_corner_turn_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_sof(out_sof), .out_re(out_re), .out_im(out_im),
    .out_row(out_row), .out_col(out_col)
  );

  function automatic logic [DATA_W-1:0] gen_re(int f, int i);
    return DATA_W'(f * 1031 + i * 7 + 1);
  endfunction

  function automatic logic [DATA_W-1:0] gen_im(int f, int i);
    return DATA_W'((f * 517) ^ (i * 13) ^ 16'h5a5a);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench model of output timing
  int  in_cnt;
  logic exp_valid;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt <= 0;
      exp_valid <= 1'b0;
    end else begin
      exp_valid <= in_valid && (in_cnt >= NN);
      if (in_valid && in_cnt < NN) in_cnt <= in_cnt + 1;
    end
  end

  // Output monitor
  int mon_k = 0;
  int mon_f = 0;
  int out_seen = 0;
  int sof_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4", 32'(out_valid), 32'(exp_valid), "out_valid timing");
      if (out_valid) begin
        int c, r;
        c = mon_k / N;
        r = mon_k % N;
        check("R6", 32'(out_col), 32'(c), "out_col");
        check("R6", 32'(out_row), 32'(r), "out_row");
        check("R5", 32'(out_sof), 32'(mon_k == 0), "out_sof");
        check("R3", 32'(out_re), 32'(gen_re(mon_f, r * N + c)), "out_re transposed");
        check("R9", 32'(out_im), 32'(gen_im(mon_f, r * N + c)), "out_im transposed");
        out_seen++;
        if (out_sof) sof_seen++;
        mon_k++;
        if (mon_k == NN) begin
          mon_k = 0;
          mon_f++;
        end
      end else begin
        check("R5", 32'(out_sof), 32'd0, "out_sof while idle");
      end
    end
  end

  int drv_f = 0;

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_frame(bit gaps);
    for (int i = 0; i < NN; i++) begin
      if (gaps && (i % 5 == 2)) idle((i % 3) + 1);
      in_valid = 1'b1;
      in_re = gen_re(drv_f, i);
      in_im = gen_im(drv_f, i);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    drv_f++;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R1", 32'(out_valid), 32'd0, "out_valid in reset");
      check("R1", 32'(out_sof), 32'd0, "out_sof in reset");
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(2);
    settle();
    check("R1", 32'(out_valid), 32'd0, "out_valid after reset");
  endtask

  task automatic t_first_frame();
    send_frame(1'b0);
    idle(3);
    settle();
    check("R2", 32'(out_seen), 32'd0, "outputs during first frame");
  endtask

  task automatic t_stream();
    int o0, s0;
    o0 = out_seen;
    s0 = sof_seen;
    for (int k = 0; k < 3; k++) send_frame(1'b0);
    settle();
    check("R8", 32'(out_seen - o0), 32'(3 * NN), "samples from back-to-back frames");
    check("R8", 32'(sof_seen - s0), 32'd3, "frame starts from back-to-back frames");
  endtask

  task automatic t_gaps();
    int o0;
    o0 = out_seen;
    send_frame(1'b1);
    idle(4);
    settle();
    check("R7", 32'(out_seen - o0), 32'(NN), "samples with gapped input");
    o0 = out_seen;
    send_frame(1'b0);
    settle();
    check("R7", 32'(out_seen - o0), 32'(NN), "samples from frame after gaps");
    check("R3", 32'(mon_f), 32'(drv_f - 1), "output frames completed");
  endtask

  initial begin
    t_reset();
    t_first_frame();
    t_stream();
    t_gaps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule